// File: doc/BRIEF.md
# Integer Shift and ALU Execute Unit

This block is the combinational execute stage for register-format integer operations. A 6-bit function code selects the operation. It works on two 32-bit source operands, called rs and rt, and also takes a 5-bit immediate shift amount and one select bit. The select bit turns a logical right shift into a rotate. The block returns a result word, a write-enable for the destination register, a signed-overflow flag and a reserved-code flag.

The surrounding pipeline decodes the instruction fields, presents the operands and function code, and then uses the outputs in the same cycle. When write-enable is low, the destination register must keep its old value. Write-enable goes low for a conditional move whose condition fails, for a signed add or subtract that overflows, and for any function code the unit does not implement.

Top module: `int_exec_unit`

## Requirements
- R1: Function code 0x00 returns rt shifted left logically by the shift-amount input, with zeros filled in.
- R2: Function code 0x02 returns rt shifted right logically by the shift-amount input when the select bit is 0. When the select bit is 1, it returns rt rotated right by that amount.
- R3: Function code 0x03 returns rt shifted right by the shift-amount input, with copies of bit 31 filled in.
- R4: Function codes 0x04, 0x06 and 0x07 behave like 0x00, 0x02 and 0x03, including the rotate on 0x06 with the select bit at 1. For these codes the amount is bits 4:0 of rs, and the upper bits of rs and the shift-amount input have no effect.
- R5: A rotate by zero, immediate or variable, returns rt unchanged.
- R6: Function code 0x0A returns rs with write-enable high only when rt is zero. Function code 0x0B returns rs with write-enable high only when rt is nonzero. Otherwise write-enable is low.
- R7: Function codes 0x20 and 0x22 return rs+rt and rs−rt, wrapped to 32 bits. On two's-complement overflow they raise the overflow flag and drive write-enable low.
- R8: Function codes 0x21 and 0x23 return the wrapped sum and difference with write-enable high. They never raise the overflow flag.
- R9: Function codes 0x24, 0x25, 0x26 and 0x27 return rs AND rt, rs OR rt, rs XOR rt and NOR of rs and rt, in that order.
- R10: Function code 0x2A returns 1 if rs is less than rt as signed values, and 0 otherwise. Code 0x2B makes the same comparison unsigned.
- R11: Any other function code raises the reserved flag, drives write-enable low and returns zero.
- R12: The select bit has no effect on any function code other than 0x02 and 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_s | input | 32 | First operand (rs); the amount source for variable shifts |
| src_t | input | 32 | Second operand (rt); the value that shifts shift |
| sh_imm | input | 5 | Immediate shift amount |
| fn_code | input | 6 | Function code |
| rot_sel | input | 1 | Chooses a rotate in place of a logical right shift |
| result | output | 32 | Result word |
| wr_en | output | 1 | Destination write-enable |
| ovf_flag | output | 1 | Signed overflow on add or subtract |
| rsvd_flag | output | 1 | Function code not implemented |

## Verification
The two functions that can coincide are overflow detection and write suppression. A signed add or subtract that overflows must raise the flag and also drop the write, while still presenting the wrapped value. The bench provokes this with operand pairs at the signed limits, such as 0x7FFFFFFF plus 1 and 0x80000000 minus 1. It sends the same pairs through the unsigned codes, which must keep write-enable high with no flag. A behavioural model computes the expected outputs with 64-bit integers and is compared against all four outputs on every clock.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
  localparam int unsigned FN_W = 6;

  typedef enum logic [FN_W-1:0] {
    FN_SLL  = 6'h00, FN_SRL  = 6'h02, FN_SRA  = 6'h03,
    FN_SLLV = 6'h04, FN_SRLV = 6'h06, FN_SRAV = 6'h07,
    FN_MOVZ = 6'h0A, FN_MOVN = 6'h0B,
    FN_ADD  = 6'h20, FN_ADDU = 6'h21, FN_SUB  = 6'h22, FN_SUBU = 6'h23,
    FN_AND  = 6'h24, FN_OR   = 6'h25, FN_XOR  = 6'h26, FN_NOR  = 6'h27,
    FN_SLT  = 6'h2A, FN_SLTU = 6'h2B
  } fn_e;

  typedef enum logic [1:0] {SK_LEFT, SK_RIGHT, SK_ARITH, SK_ROTR} shift_kind_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} logic_op_e;
  typedef enum logic [2:0] {SEL_ZERO, SEL_SHIFT, SEL_SUM, SEL_LOGIC,
                            SEL_LT_S, SEL_LT_U, SEL_PASS_S} res_sel_e;
endpackage

// File: rtl/ieu_shifter.sv
module ieu_shifter
  import ieu_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  value,
  input  logic [AW-1:0] amount,
  input  shift_kind_e   kind,
  output logic [W-1:0]  out
);
  // Rotate via a doubled word: no shift by W ever occurs.
  function automatic logic [W-1:0] rot_right(input logic [W-1:0] v, input logic [AW-1:0] a);
    logic [2*W-1:0] dbl;
    dbl = {v, v} >> a;
    return dbl[W-1:0];
  endfunction

  function automatic logic [W-1:0] sar(input logic [W-1:0] v, input logic [AW-1:0] a);
    return W'($signed(v) >>> a);
  endfunction

  always_comb begin
    unique case (kind)
      SK_LEFT:  out = value << amount;
      SK_RIGHT: out = value >> amount;
      SK_ARITH: out = sar(value, amount);
      default:  out = rot_right(value, amount);
    endcase
  end

  always_comb begin
    p_rotate_zero_r5: assert (!(kind == SK_ROTR && amount == '0 && out != value));
  end
endmodule

// File: rtl/ieu_addsub.sv
module ieu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  logic [W-1:0] b_eff;
  logic [W-1:0] diff;
  logic         diff_ovf;

  function automatic logic sgn_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  assign b_eff = subtract ? ~b : b;
  assign sum   = a + b_eff + {{(W-1){1'b0}}, subtract};
  assign ovf   = sgn_ovf(a[W-1], b_eff[W-1], sum[W-1]);

  // Comparison path always subtracts.
  assign diff        = a - b;
  assign diff_ovf    = sgn_ovf(a[W-1], ~b[W-1], diff[W-1]);
  assign lt_signed   = diff[W-1] ^ diff_ovf;
  assign lt_unsigned = a < b;
endmodule

// File: rtl/ieu_logic.sv
module ieu_logic
  import ieu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_op_e    op,
  output logic [W-1:0] out
);
  always_comb begin
    unique case (op)
      LG_AND:  out = a & b;
      LG_OR:   out = a | b;
      LG_XOR:  out = a ^ b;
      default: out = ~(a | b);
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ieu_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  src_s,
  input  logic [W-1:0]  src_t,
  input  logic [AW-1:0] sh_imm,
  input  logic [FN_W-1:0] fn_code,
  input  logic          rot_sel,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic          ovf_flag,
  output logic          rsvd_flag
);
  // Decoded controls, brought out as named wires.
  shift_kind_e sh_kind;
  logic [AW-1:0] sh_amt;
  logic_op_e   lg_op;
  res_sel_e    rsel;
  logic        do_sub, chk_ovf, is_cmov, cmov_ok, is_cmp;

  logic [W-1:0] sh_out, as_sum, lg_out;
  logic         as_ovf, lt_s, lt_u;

  always_comb begin
    sh_kind = SK_LEFT;  sh_amt = sh_imm;  lg_op = LG_AND;
    rsel = SEL_ZERO;    do_sub = 1'b0;    chk_ovf = 1'b0;
    is_cmov = 1'b0;     cmov_ok = 1'b0;   is_cmp = 1'b0;
    rsvd_flag = 1'b0;
    case (fn_code)
      FN_SLL:  begin rsel = SEL_SHIFT; end
      FN_SRL:  begin rsel = SEL_SHIFT; sh_kind = rot_sel ? SK_ROTR : SK_RIGHT; end
      FN_SRA:  begin rsel = SEL_SHIFT; sh_kind = SK_ARITH; end
      FN_SLLV: begin rsel = SEL_SHIFT; sh_amt = src_s[AW-1:0]; end
      FN_SRLV: begin rsel = SEL_SHIFT; sh_amt = src_s[AW-1:0];
                     sh_kind = rot_sel ? SK_ROTR : SK_RIGHT; end
      FN_SRAV: begin rsel = SEL_SHIFT; sh_amt = src_s[AW-1:0]; sh_kind = SK_ARITH; end
      FN_MOVZ: begin rsel = SEL_PASS_S; is_cmov = 1'b1; cmov_ok = (src_t == '0); end
      FN_MOVN: begin rsel = SEL_PASS_S; is_cmov = 1'b1; cmov_ok = (src_t != '0); end
      FN_ADD:  begin rsel = SEL_SUM; chk_ovf = 1'b1; end
      FN_ADDU: begin rsel = SEL_SUM; end
      FN_SUB:  begin rsel = SEL_SUM; do_sub = 1'b1; chk_ovf = 1'b1; end
      FN_SUBU: begin rsel = SEL_SUM; do_sub = 1'b1; end
      FN_AND:  begin rsel = SEL_LOGIC; lg_op = LG_AND; end
      FN_OR:   begin rsel = SEL_LOGIC; lg_op = LG_OR;  end
      FN_XOR:  begin rsel = SEL_LOGIC; lg_op = LG_XOR; end
      FN_NOR:  begin rsel = SEL_LOGIC; lg_op = LG_NOR; end
      FN_SLT:  begin rsel = SEL_LT_S; is_cmp = 1'b1; end
      FN_SLTU: begin rsel = SEL_LT_U; is_cmp = 1'b1; end
      default: rsvd_flag = 1'b1;
    endcase
  end

  ieu_shifter #(.W(W)) u_shift (
    .value(src_t), .amount(sh_amt), .kind(sh_kind), .out(sh_out)
  );

  ieu_addsub #(.W(W)) u_addsub (
    .a(src_s), .b(src_t), .subtract(do_sub), .sum(as_sum), .ovf(as_ovf),
    .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  ieu_logic #(.W(W)) u_logic (
    .a(src_s), .b(src_t), .op(lg_op), .out(lg_out)
  );

  always_comb begin
    unique case (rsel)
      SEL_SHIFT:  result = sh_out;
      SEL_SUM:    result = as_sum;
      SEL_LOGIC:  result = lg_out;
      SEL_LT_S:   result = {{(W-1){1'b0}}, lt_s};
      SEL_LT_U:   result = {{(W-1){1'b0}}, lt_u};
      SEL_PASS_S: result = src_s;
      default:    result = '0;
    endcase
    ovf_flag = chk_ovf & as_ovf;
    wr_en    = !rsvd_flag && !ovf_flag && (!is_cmov || cmov_ok);
  end

  always_comb begin
    p_reserved_no_write_r11: assert (!(rsvd_flag && (wr_en || result != '0)));
    p_no_overflow_r7: assert (!(ovf_flag && wr_en));
    p_unsigned_no_flag_r8: assert (!(ovf_flag && (fn_code == FN_ADDU || fn_code == FN_SUBU)));
    p_cmove_value_r6: assert (!(is_cmov && result != src_s));
    p_compare_bool_r10: assert (!(is_cmp && result[W-1:1] != '0));
  end
endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] src_s, src_t, result;
  logic [4:0]  sh_imm;
  logic [5:0]  fn_code;
  logic        rot_sel, wr_en, ovf_flag, rsvd_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int_exec_unit u_int_exec_unit (
    .src_s(src_s), .src_t(src_t), .sh_imm(sh_imm), .fn_code(fn_code),
    .rot_sel(rot_sel), .result(result), .wr_en(wr_en),
    .ovf_flag(ovf_flag), .rsvd_flag(rsvd_flag)
  );

  function automatic string req_of(input logic [5:0] f, input logic sel);
    case (f)
      6'h00: return "R1";
      6'h02: return sel ? "R2/R5" : "R2";
      6'h03: return "R3";
      6'h04, 6'h06, 6'h07: return "R4";
      6'h0A, 6'h0B: return "R6";
      6'h20, 6'h22: return "R7";
      6'h21, 6'h23: return "R8";
      6'h24, 6'h25, 6'h26, 6'h27: return "R9";
      6'h2A, 6'h2B: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Behavioural reference: bit loops and 64-bit integers.
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [4:0] sa,
                       input logic [5:0] f, input logic sel,
                       output logic [31:0] r, output logic we, output logic ov, output logic rv);
    int amt;
    longint x;
    logic [31:0] v;
    r = 0; we = 1; ov = 0; rv = 0;
    amt = f[2] ? int'(a & 32'h1F) : int'(sa);
    v = b;
    case (f)
      6'h00, 6'h04: for (int i = 0; i < amt; i++) v = {v[30:0], 1'b0};
      6'h02, 6'h06: for (int i = 0; i < amt; i++) v = sel ? {v[0], v[31:1]} : {1'b0, v[31:1]};
      6'h03, 6'h07: for (int i = 0; i < amt; i++) v = {v[31], v[31:1]};
      default: ;
    endcase
    case (f)
      6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07: r = v;
      6'h0A: begin r = a; we = (b == 0); end
      6'h0B: begin r = a; we = (b != 0); end
      6'h20, 6'h21, 6'h22, 6'h23: begin
        x = (f[1]) ? longint'($signed(a)) - longint'($signed(b))
                   : longint'($signed(a)) + longint'($signed(b));
        r = x[31:0];
        if (!f[0] && (x > 64'sd2147483647 || x < -64'sd2147483648)) begin ov = 1; we = 0; end
      end
      6'h24: r = a & b;
      6'h25: r = a | b;
      6'h26: r = a ^ b;
      6'h27: r = ~(a | b);
      6'h2A: r = (longint'($signed(a)) < longint'($signed(b))) ? 1 : 0;
      6'h2B: r = (longint'({32'd0, a}) < longint'({32'd0, b})) ? 1 : 0;
      default: begin rv = 1; we = 0; end
    endcase
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [4:0] sa,
                       input logic [5:0] f, input logic sel);
    logic [31:0] er;
    logic ew, eo, ev;
    @(posedge clk);
    src_s = a; src_t = b; sh_imm = sa; fn_code = f; rot_sel = sel;
    @(negedge clk);
    model(a, b, sa, f, sel, er, ew, eo, ev);
    checks++;
    if (result !== er || wr_en !== ew || ovf_flag !== eo || rsvd_flag !== ev) begin
      errors++;
      $display("FAIL %s fn=%02h a=%08h b=%08h sa=%0d sel=%0b: got r=%08h we=%0b ov=%0b rv=%0b exp r=%08h we=%0b ov=%0b rv=%0b",
               req_of(f, sel), f, a, b, sa, sel, result, wr_en, ovf_flag, rsvd_flag, er, ew, eo, ev);
    end
  endtask

  initial begin
    logic [5:0] codes [18] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h0A, 6'h0B,
                               6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
                               6'h2A, 6'h2B};
    src_s = 0; src_t = 0; sh_imm = 0; fn_code = 0; rot_sel = 0;
    apply(0, 0, 0, 6'h00, 0);                           // quiet start
    apply(0, 32'h8000_0001, 31, 6'h00, 0);              // R1
    apply(0, 32'h8000_0001, 4, 6'h02, 0);               // R2 logical
    apply(0, 32'h8000_0001, 4, 6'h02, 1);               // R2 rotate
    apply(0, 32'hDEAD_BEEF, 0, 6'h02, 1);               // R5 immediate
    apply(32'hFFFF_FFE0, 32'hDEAD_BEEF, 7, 6'h06, 1);   // R5 variable, amount 0
    apply(0, 32'h8000_0000, 31, 6'h03, 0);              // R3
    apply(0, 32'h8000_0000, 31, 6'h03, 1);              // R12
    apply(32'h1234_5668, 32'h0000_00F1, 3, 6'h04, 0);   // R4 upper bits ignored
    apply(32'h0000_0023, 32'hF000_000F, 0, 6'h06, 1);   // R4 rotate
    apply(32'hFFFF_FFFF, 32'h8000_0000, 0, 6'h07, 0);   // R4 sra by 31
    apply(32'hCAFE_0001, 0, 0, 6'h0A, 0);               // R6 movz taken
    apply(32'hCAFE_0001, 5, 0, 6'h0A, 0);               // R6 movz suppressed
    apply(32'hCAFE_0001, 0, 0, 6'h0B, 1);               // R6 movn suppressed, R12
    apply(32'hCAFE_0001, 1, 0, 6'h0B, 0);               // R6 movn taken
    apply(32'h7FFF_FFFF, 1, 0, 6'h20, 0);               // R7 add overflow
    apply(32'h8000_0000, 1, 0, 6'h22, 0);               // R7 sub overflow
    apply(32'h8000_0000, 32'h8000_0000, 0, 6'h20, 1);   // R7 neg overflow, R12
    apply(32'hFFFF_FFFF, 1, 0, 6'h20, 0);               // R7 no overflow
    apply(32'h7FFF_FFFF, 1, 0, 6'h21, 0);               // R8
    apply(32'h8000_0000, 1, 0, 6'h23, 0);               // R8
    apply(32'hF0F0_1234, 32'h0FF0_4321, 0, 6'h27, 0);   // R9
    apply(32'hFFFF_FFFF, 1, 0, 6'h2A, 0);               // R10 signed less
    apply(32'hFFFF_FFFF, 1, 0, 6'h2B, 0);               // R10 unsigned not less
    apply(32'h8000_0000, 32'h7FFF_FFFF, 0, 6'h2A, 0);   // R10 extremes
    apply(5, 5, 0, 6'h2B, 0);                           // R10 equal
    apply(32'h1111_1111, 2, 3, 6'h01, 0);               // R11
    apply(32'h1111_1111, 2, 3, 6'h05, 1);               // R11
    apply(32'h1111_1111, 2, 3, 6'h3F, 0);               // R11
    for (int n = 0; n < 2000; n++) begin
      logic [5:0] f;
      f = (n % 8 == 7) ? 6'($urandom) : codes[$urandom_range(0, 17)];
      apply($urandom, (n % 5 == 0) ? 32'h0 : $urandom, 5'($urandom), f, 1'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule